// File: doc/BRIEF.md
# Card Bus Clock Divider

This block makes the clock for a memory-card bus from a faster kernel clock. A register-programmed divider value sets the ratio. A non-zero value N gives a card clock whose period is 2·N kernel cycles, with equal high and low halves. A value of zero selects bypass, where the kernel clock itself is passed to the card. Double-data-rate operation cannot use bypass, so in that mode a zero is forced to a divider of one. The divider field has a fixed width, so the slowest clock is the one the largest value in the field gives. A request for a zero frequency is therefore programmed as that maximum value, and the clock keeps running.

The clock stops only when the enable input is low, which is how power-off and power-cycle states are shown. Otherwise it runs. A new setting is taken only at the end of a low half of the card clock, so a change can never cut a pulse short. The block also drives out a configuration word. This word reflects the setting currently in force: the effective divider, the bypass flag, the DDR flag and the bus-width code. Software or neighbouring logic can see from it when a change has taken effect.

Top module: `card_clk_div`

## Requirements
- R1: With an effective divider D ≥ 1, each high and each low half of the card clock lasts exactly D kernel-clock cycles.
- R2: A programmed divider of zero with DDR off selects bypass. The card clock then follows the kernel clock: it is high while the kernel clock is high and low while it is low.
- R3: A programmed divider of zero with DDR on never selects bypass. The divider is forced to 1, so the card clock has a half-period of one kernel cycle.
- R4: The largest value the divider field can hold, 2^DIV_W−1, gives the longest half-period, 2^DIV_W−1 kernel cycles.
- R5: While the enable is low, the card clock is held low and the configuration word follows the inputs. Once the enable returns, the first rising edge comes on the D-th kernel edge with the enable high.
- R6: While the divided clock runs, a changed setting takes effect only at the end of a low half. The high and low halves in progress keep the old length, and the next high half uses the new one.
- R7: The configuration word holds the setting in force. Bits [DIV_W-1:0] are the effective divider (0 in bypass). Bit DIV_W is bypass. Bit DIV_W+1 is DDR. Bits [DIV_W+3:DIV_W+2] are the bus-width code, passed through unchanged. The word changes in the same cycle the setting takes effect.
- R8: After reset the card clock is low and the configuration word reads an effective divider of 1, with every flag and the width code at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock run enable; low stops the card clock |
| div_val | input | DIV_W | Programmed divider value, 0 = bypass |
| ddr_mode | input | 1 | Double-data-rate mode request |
| bus_width | input | 2 | Bus-width code, mirrored only |
| card_clk | output | 1 | Generated card clock |
| cfg_word | output | DIV_W+4 | Setting currently in force |

## Verification
Some properties hold on every kernel cycle. Each high half matches the divider that was in force when it began. The configuration word changes only at the end of a low half, or while the clock is stopped or in bypass. DDR and bypass are never in force together. The divided level stays low while the clock is stopped or bypassed. Other behaviours only the scenarios show. These are the full-length low halves, the mid-run change of setting with its old-then-new half lengths, the first edge after a restart, and the bypass clock that follows the kernel clock level in both of its phases.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    // Bus-width code carried through to the configuration word.
    typedef enum logic [1:0] {
        CCD_BW_1   = 2'd0,
        CCD_BW_4   = 2'd1,
        CCD_BW_8   = 2'd2,
        CCD_BW_RSV = 2'd3
    } ccd_bw_e;

    // Flag and width bits that sit above the divider in the config word.
    localparam int unsigned CCD_CFG_XTRA = 4;

    // Bypass is chosen only for a zero divider outside DDR mode.
    function automatic logic ccd_pick_bypass(input logic div_zero, input logic ddr);
        return div_zero && !ddr;
    endfunction

    // A zero divider in DDR mode is forced up to one.
    function automatic logic ccd_force_one(input logic div_zero, input logic ddr);
        return div_zero && ddr;
    endfunction

endpackage

// File: rtl/ccd_cfg_resolve.sv
module ccd_cfg_resolve #(
    parameter int unsigned DIV_W = 8,
    localparam int unsigned CFG_W = DIV_W + ccd_pkg::CCD_CFG_XTRA
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic             ddr_mode,
    input  logic [1:0]       bus_width,
    output logic [CFG_W-1:0] req_cfg
);
    import ccd_pkg::*;

    typedef struct packed {
        ccd_bw_e          width;
        logic             ddr;
        logic             bypass;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    cfg_t req;
    logic div_zero;

    always_comb begin
        div_zero   = (div_val == '0);
        req.width  = ccd_bw_e'(bus_width);
        req.ddr    = ddr_mode;
        req.bypass = ccd_pick_bypass(div_zero, ddr_mode);
        if (ccd_force_one(div_zero, ddr_mode)) begin
            req.div = DIV_ONE;
        end else begin
            req.div = div_val;
        end
    end

    assign req_cfg = req;

endmodule

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen #(
    parameter int unsigned DIV_W = 8,
    localparam int unsigned CFG_W = DIV_W + ccd_pkg::CCD_CFG_XTRA
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic [CFG_W-1:0] req_cfg,
    output logic [CFG_W-1:0] app_cfg,
    output logic             lvl
);
    import ccd_pkg::*;

    typedef struct packed {
        ccd_bw_e          width;
        logic             ddr;
        logic             bypass;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    cfg_t             req;
    cfg_t             app_q;
    logic [DIV_W-1:0] cnt_q;
    logic             lvl_q;
    logic             end_half;

    assign req      = cfg_t'(req_cfg);
    assign end_half = (cnt_q == (app_q.div - DIV_ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            app_q <= '{width: CCD_BW_1, ddr: 1'b0, bypass: 1'b0, div: DIV_ONE};
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (!clk_en || app_q.bypass) begin
            // Stopped or bypassed: follow the request, keep the divided level low.
            app_q <= req;
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (end_half) begin
            cnt_q <= '0;
            if (lvl_q) begin
                lvl_q <= 1'b0;
            end else begin
                // End of a low half: the only point a new setting is taken.
                app_q <= req;
                lvl_q <= !req.bypass;
            end
        end else begin
            cnt_q <= cnt_q + DIV_ONE;
        end
    end

    assign app_cfg = app_q;
    assign lvl     = lvl_q;

endmodule

// File: rtl/ccd_bypass_gate.sv
module ccd_bypass_gate (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic bypass,
    input  logic lvl,
    output logic card_clk
);
    logic gate_q;

    // Updated on the falling kernel edge so the gate only moves while clk is low.
    always_ff @(negedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= bypass && clk_en;
        end
    end

    assign card_clk = (clk && gate_q) || lvl;

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
    parameter int unsigned DIV_W = 8,
    localparam int unsigned CFG_W = DIV_W + ccd_pkg::CCD_CFG_XTRA
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ddr_mode,
    input  logic [1:0]       bus_width,
    output logic             card_clk,
    output logic [CFG_W-1:0] cfg_word
);
    logic [CFG_W-1:0] req_cfg;
    logic [CFG_W-1:0] app_cfg;
    logic             div_lvl;

    ccd_cfg_resolve #(.DIV_W(DIV_W)) u_resolve (
        .div_val  (div_val),
        .ddr_mode (ddr_mode),
        .bus_width(bus_width),
        .req_cfg  (req_cfg)
    );

    ccd_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .clk_en (clk_en),
        .req_cfg(req_cfg),
        .app_cfg(app_cfg),
        .lvl    (div_lvl)
    );

    ccd_bypass_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .clk_en  (clk_en),
        .bypass  (app_cfg[DIV_W]),
        .lvl     (div_lvl),
        .card_clk(card_clk)
    );

    assign cfg_word = app_cfg;

endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
    parameter int unsigned DIV_W = 8,
    localparam int unsigned CFG_W = DIV_W + ccd_pkg::CCD_CFG_XTRA
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en,
    input logic [CFG_W-1:0] cfg_word,
    input logic             div_lvl
);
    logic [DIV_W:0] hi_len_q;

    // Counts cycles spent in the current high half of the divided clock.
    always_ff @(posedge clk) begin
        if (rst || !div_lvl) begin
            hi_len_q <= '0;
        end else begin
            hi_len_q <= hi_len_q + 1'b1;
        end
    end

    // R1: a high half lasts exactly the divider in force.
    a_r1_high_half_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(div_lvl) && $past(clk_en)) |->
            ($past(hi_len_q) + 1'b1 == {1'b0, $past(cfg_word[DIV_W-1:0])}));

    // R3: DDR and bypass are never in force together.
    a_r3_ddr_no_bypass: assert property (@(posedge clk) disable iff (rst)
        cfg_word[DIV_W+1] |-> !cfg_word[DIV_W]);

    // R2: in bypass the divided level stays low.
    a_r2_bypass_level_low: assert property (@(posedge clk) disable iff (rst)
        cfg_word[DIV_W] |-> !div_lvl);

    // R5: a low enable forces the divided level low on the next cycle.
    a_r5_stop_low: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> !div_lvl);

    // R6: while running divided, the setting changes only as a low half ends.
    a_r6_change_at_low_end: assert property (@(posedge clk) disable iff (rst)
        ((cfg_word != $past(cfg_word)) && $past(clk_en) && !$past(cfg_word[DIV_W]))
            |-> !$past(div_lvl));

endmodule

bind card_clk_div card_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_en  (clk_en),
    .cfg_word(cfg_word),
    .div_lvl (div_lvl)
);

// File: tb/card_clk_div_bench.sv
module card_clk_div_bench;
    localparam int unsigned DIV_W    = 3;
    localparam int unsigned CFG_W    = DIV_W + 4;
    localparam time         CLK_HALF = 5;
    localparam int          WD_LIMIT = 100000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clk_en = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic             ddr_mode = 1'b0;
    logic [1:0]       bus_width = 2'd0;
    logic             card_clk;
    logic [CFG_W-1:0] cfg_word;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #CLK_HALF clk = ~clk;

    card_clk_div #(.DIV_W(DIV_W)) u_card_clk_div (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .div_val  (div_val),
        .ddr_mode (ddr_mode),
        .bus_width(bus_width),
        .card_clk (card_clk),
        .cfg_word (cfg_word)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cfg(input int d, input bit ddr, input int w);
        int eff;
        bit byp;
        byp = (d == 0) && !ddr;
        eff = (d == 0) ? (ddr ? 1 : 0) : d;
        return (w << (DIV_W + 2)) | (int'(ddr) << (DIV_W + 1)) | (int'(byp) << DIV_W) | eff;
    endfunction

    task automatic tick_low();
        @(negedge clk);
        #1;
    endtask

    // Waits for a fresh rising edge of the divided clock (sampled low then high).
    task automatic sync_rise();
        int g = 0;
        while (card_clk !== 1'b0 && g < 200) begin tick_low(); g++; end
        while (card_clk !== 1'b1 && g < 400) begin tick_low(); g++; end
    endtask

    // Length in kernel cycles of the run that holds the current level.
    task automatic run_len(output int len);
        logic lv;
        lv  = card_clk;
        len = 0;
        while (card_clk === lv && len < 200) begin
            len++;
            tick_low();
        end
    endtask

    task automatic measure(input int exp, input string req);
        int len;
        sync_rise();
        for (int k = 0; k < 4; k++) begin
            run_len(len);
            check(len == exp, req, len, exp);
        end
    endtask

    initial begin
        while (cycles < WD_LIMIT) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        int len;
        repeat (3) tick_low();
        // R8: reset state.
        check(card_clk == 1'b0, "R8 clock low", int'(card_clk), 0);
        check(int'(cfg_word) == 1, "R8 cfg word", int'(cfg_word), 1);
        rst = 1'b0;
        tick_low();

        // Sweep every divider value with DDR off and on (R1, R2, R3, R4, R7).
        for (int d = 0; d < (1 << DIV_W); d++) begin
            for (int m = 0; m < 2; m++) begin
                clk_en    = 1'b0;
                div_val   = DIV_W'(d);
                ddr_mode  = m[0];
                bus_width = 2'(d % 4);
                repeat (2) tick_low();
                check(int'(cfg_word) == exp_cfg(d, m[0], d % 4), "R7 cfg mirror",
                      int'(cfg_word), exp_cfg(d, m[0], d % 4));
                clk_en = 1'b1;
                if (d == 0 && m == 0) begin
                    repeat (3) tick_low();
                    for (int k = 0; k < 4; k++) begin
                        check(card_clk == 1'b0, "R2 bypass low phase", int'(card_clk), 0);
                        @(posedge clk);
                        #1;
                        check(card_clk == 1'b1, "R2 bypass high phase", int'(card_clk), 1);
                        tick_low();
                    end
                end else if (d == 0) begin
                    measure(1, "R3 ddr zero forced to one");
                end else if (d == (1 << DIV_W) - 1) begin
                    measure(d, "R4 max divider");
                end else begin
                    measure(d, "R1 half period");
                end
            end
        end

        // R5: stop holds low; restart rises on the D-th enabled edge.
        clk_en = 1'b1; div_val = 3'd4; ddr_mode = 1'b0; bus_width = 2'd1;
        sync_rise();
        clk_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick_low();
            check(card_clk == 1'b0, "R5 stopped low", int'(card_clk), 0);
        end
        clk_en = 1'b1;
        tick_low();
        run_len(len);
        check(len == 3, "R5 first low after restart", len, 3);
        run_len(len);
        check(len == 4, "R5 first high after restart", len, 4);

        // R6: change from 3 to 5 just after a rise.
        div_val = 3'd3;
        clk_en  = 1'b0;
        repeat (2) tick_low();
        clk_en = 1'b1;
        sync_rise();
        div_val = 3'd5;
        run_len(len);
        check(len == 3, "R6 current high keeps old", len, 3);
        check(int'(cfg_word[DIV_W-1:0]) == 3, "R6 cfg old during low",
              int'(cfg_word[DIV_W-1:0]), 3);
        run_len(len);
        check(len == 3, "R6 following low keeps old", len, 3);
        check(int'(cfg_word[DIV_W-1:0]) == 5, "R6 cfg new after rise",
              int'(cfg_word[DIV_W-1:0]), 5);
        run_len(len);
        check(len == 5, "R6 next high uses new", len, 5);
        run_len(len);
        check(len == 5, "R6 next low uses new", len, 5);

        // R6 into bypass from divided and back out.
        div_val = 3'd0;
        repeat (14) tick_low();
        check(cfg_word[DIV_W] == 1'b1, "R6 bypass taken", int'(cfg_word[DIV_W]), 1);
        @(posedge clk);
        #1;
        check(card_clk == 1'b1, "R2 bypass after switch", int'(card_clk), 1);
        div_val = 3'd2;
        tick_low();
        measure(2, "R6 leave bypass");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule